// File: doc/BRIEF.md
# Power-on Strap Capture and Startup Sequencer

This block runs a single startup sequence after reset. It samples three configuration strap pins through a synchroniser and latches them once as the operating-mode code. The code is exposed as a read-only byte. In the two modes that carry a rotary address switch, the block then reads that 8-bit switch. It pulls a dedicated active-low switch select low, waits a configurable number of clocks, and captures the value present on the shared data lines into a configuration register. The block never drives those lines.

The active-low peripheral reset stays asserted from reset until the switch read is over. This keeps the peripheral off the shared data lines while the switch is on them. In the mode without a switch, and for mode codes that have no defined meaning, the read phase is skipped and the peripheral is released straight away. A completion flag goes high together with the release and stays high until the next reset.

Top module: `boot_strap_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the outputs rest at `periph_rst_n_o`=0, `sw_cs_n_o`=1, `startup_done_o`=0, `mode_reg_o`=0x00 and `cfg_switch_o`=0x00.
- R2: On the first clock edge after `rst` falls, the synchronised strap code {strap[2],strap[1],strap[0]} is latched. It then appears in bits 2..0 of `mode_reg_o`, and bits 7..3 read zero. The code values are 000 bus mode, 001 I/O mode and 010 dual-port memory mode.
- R3: Strap changes after the latch edge have no effect on `mode_reg_o` until the next reset.
- R4: In codes 000 and 010, `sw_cs_n_o` goes low at the latch edge and stays low for exactly SEL_CYCLES clocks (default 8). After that it is never low again until the next reset.
- R5: `cfg_switch_o` takes the value on `sw_data_i` at the edge that ends the select window. Later changes on `sw_data_i` leave it unchanged.
- R6: `periph_rst_n_o` stays low for as long as `sw_cs_n_o` is low. It rises on the same edge at which `sw_cs_n_o` returns high.
- R7: In code 001, `sw_cs_n_o` never goes low and `cfg_switch_o` stays 0x00. `periph_rst_n_o` rises at the latch edge.
- R8: Codes 011 to 111 behave like code 001 for the read phase and the reset release. `mode_reg_o` still reports the latched code.
- R9: `startup_done_o` rises on the same edge as `periph_rst_n_o` and stays high until `rst` is asserted again. The sequence does not repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Asynchronous mode strap pins |
| sw_data_i | input | 8 | Receive side of the shared data lines |
| sw_cs_n_o | output | 1 | Active-low switch select |
| periph_rst_n_o | output | 1 | Active-low peripheral reset |
| mode_reg_o | output | 8 | Read-only mode byte |
| cfg_switch_o | output | 8 | Stored switch value |
| startup_done_o | output | 1 | Sequence complete |

## Verification
Edges are counted from the first rising edge after `rst` falls, called E1. The mode byte and the select fall are due right after E1. In the non-read codes, the peripheral release and the done flag are also due after E1. In the read codes, the select stays low after E1 through E(SEL_CYCLES). The captured switch value, the select rise, the peripheral release and the done flag are all due after edge E(1+SEL_CYCLES). The bench samples every output at the falling edge that follows the counted rising edge. It holds the wanted switch value on the data lines only during the last select cycle, with a different value before and after. This shows that the capture is taken at exactly the closing edge.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned REG_W  = 8;

    typedef logic [MODE_W-1:0] mode_code_t;

    localparam mode_code_t MODE_BUS   = 3'b000;
    localparam mode_code_t MODE_IO    = 3'b001;
    localparam mode_code_t MODE_DPRAM = 3'b010;

    typedef enum logic [1:0] {
        SEQ_LATCH = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic sel_n;
        logic prst_n;
        logic done;
    } seq_ctrl_t;

    localparam seq_ctrl_t CTRL_RESET = '{sel_n: 1'b1, prst_n: 1'b0, done: 1'b0};

    function automatic logic mode_reads_switch(input mode_code_t m);
        return (m == MODE_BUS) || (m == MODE_DPRAM);
    endfunction

    function automatic logic [REG_W-1:0] mode_to_byte(input mode_code_t m);
        return {{(REG_W-MODE_W){1'b0}}, m};
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) stage_q[0] <= async_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
    import strap_seq_pkg::*;
#(
    parameter int unsigned SEL_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  mode_code_t strap_sync_i,
    output mode_code_t mode_o,
    output seq_ctrl_t  ctrl_o,
    output logic       capture_o
);
    localparam int unsigned CNT_W = $clog2(SEL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEL_CYCLES - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    mode_code_t       mode_q;
    seq_ctrl_t        ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_LATCH;
            cnt_q   <= '0;
            mode_q  <= MODE_BUS;
            ctrl_q  <= CTRL_RESET;
        end else begin
            case (state_q)
                SEQ_LATCH: begin
                    mode_q <= strap_sync_i;
                    cnt_q  <= '0;
                    if (mode_reads_switch(strap_sync_i)) begin
                        state_q      <= SEQ_READ;
                        ctrl_q.sel_n <= 1'b0;
                    end else begin
                        state_q       <= SEQ_DONE;
                        ctrl_q.prst_n <= 1'b1;
                        ctrl_q.done   <= 1'b1;
                    end
                end
                SEQ_READ: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q       <= SEQ_DONE;
                        ctrl_q.sel_n  <= 1'b1;
                        ctrl_q.prst_n <= 1'b1;
                        ctrl_q.done   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_DONE;
            endcase
        end
    end

    assign capture_o = (state_q == SEQ_READ) && (cnt_q == CNT_LAST);
    assign mode_o    = mode_q;
    assign ctrl_o    = ctrl_q;

    // R6: the peripheral is never out of reset while the switch is selected
    assert_sel_holds_reset_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.sel_n |-> !ctrl_q.prst_n);

    // R6: the select rise and the reset release share one edge
    assert_release_with_sel_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.sel_n) |-> $rose(ctrl_q.prst_n));

    // R4: once finished, the select never drops again
    assert_no_sel_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.done |-> ctrl_q.sel_n);

    // R3: the latched mode is frozen after the sequence ends
    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.done |=> $stable(mode_q));

    // R9: completion is sticky until reset
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.done |=> ctrl_q.done);

    // R9: done and the reset release agree
    assert_done_tracks_release_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.done == ctrl_q.prst_n);

    // R7/R8: modes without a switch never select it
    assert_no_sel_without_switch_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_LATCH && !mode_reads_switch(mode_q)) |-> ctrl_q.sel_n);
endmodule

// File: rtl/switch_capture.sv
module switch_capture
    import strap_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [REG_W-1:0] data_i,
    output logic [REG_W-1:0] cfg_o
);
    logic [REG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (load_i) cfg_q <= data_i;
    end

    assign cfg_o = cfg_q;

    // R5: the stored value moves only on a capture
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/boot_strap_seq.sv
module boot_strap_seq
    import strap_seq_pkg::*;
#(
    parameter int unsigned SEL_CYCLES  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_i,
    input  logic [7:0] sw_data_i,
    output logic       sw_cs_n_o,
    output logic       periph_rst_n_o,
    output logic [7:0] mode_reg_o,
    output logic [7:0] cfg_switch_o,
    output logic       startup_done_o
);
    mode_code_t strap_sync;
    mode_code_t mode_code;
    seq_ctrl_t  ctrl;
    logic       capture;

    strap_sync #(.WIDTH(MODE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .async_i (strap_i),
        .sync_o  (strap_sync)
    );

    startup_fsm #(.SEL_CYCLES(SEL_CYCLES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .strap_sync_i (strap_sync),
        .mode_o       (mode_code),
        .ctrl_o       (ctrl),
        .capture_o    (capture)
    );

    switch_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .load_i (capture),
        .data_i (sw_data_i),
        .cfg_o  (cfg_switch_o)
    );

    assign sw_cs_n_o      = ctrl.sel_n;
    assign periph_rst_n_o = ctrl.prst_n;
    assign startup_done_o = ctrl.done;
    assign mode_reg_o     = mode_to_byte(mode_code);

    // R7: without a switch read the stored value stays cleared
    assert_cfg_clear_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.done && !mode_reads_switch(mode_code)) |-> (cfg_switch_o == '0));
endmodule

// File: tb/boot_strap_seq_tb.sv
module boot_strap_seq_tb;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] strap_i = 3'b000;
    logic [7:0] sw_data_i = 8'h00;
    logic       sw_cs_n_o, periph_rst_n_o, startup_done_o;
    logic [7:0] mode_reg_o, cfg_switch_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    boot_strap_seq #(.SEL_CYCLES(N)) u_dut (
        .clk(clk), .rst(rst), .strap_i(strap_i), .sw_data_i(sw_data_i),
        .sw_cs_n_o(sw_cs_n_o), .periph_rst_n_o(periph_rst_n_o),
        .mode_reg_o(mode_reg_o), .cfg_switch_o(cfg_switch_o),
        .startup_done_o(startup_done_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset with a strap value, ending at a negedge with rst just released
    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        rst = 1'b1;
        strap_i = s;
        repeat (4) @(negedge clk);
        chk("R1 prst_n", {7'd0, periph_rst_n_o}, 8'h00);
        chk("R1 sel_n",  {7'd0, sw_cs_n_o}, 8'h01);
        chk("R1 done",   {7'd0, startup_done_o}, 8'h00);
        chk("R1 mode",   mode_reg_o, 8'h00);
        chk("R1 cfg",    cfg_switch_o, 8'h00);
        rst = 1'b0;
    endtask

    task automatic run_read_mode(input logic [2:0] s, input logic [7:0] val);
        do_reset(s);
        sw_data_i = ~val;
        @(posedge clk);           // E1: latch
        #1 strap_i = ~s;          // R3 stimulus
        for (int k = 1; k <= N; k++) begin
            @(negedge clk);
            chk("R2 mode", mode_reg_o, {5'd0, s});
            chk("R4 sel low", {7'd0, sw_cs_n_o}, 8'h00);
            chk("R6 prst held", {7'd0, periph_rst_n_o}, 8'h00);
            chk("R9 done low", {7'd0, startup_done_o}, 8'h00);
            if (k == N) sw_data_i = val;
        end
        @(posedge clk);           // E(N+1): capture
        @(negedge clk);
        sw_data_i = val ^ 8'h5A;
        chk("R5 captured", cfg_switch_o, val);
        chk("R4 sel high", {7'd0, sw_cs_n_o}, 8'h01);
        chk("R6 released", {7'd0, periph_rst_n_o}, 8'h01);
        chk("R9 done", {7'd0, startup_done_o}, 8'h01);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R5 cfg held", cfg_switch_o, val);
            chk("R4 no reselect", {7'd0, sw_cs_n_o}, 8'h01);
            chk("R3 mode held", mode_reg_o, {5'd0, s});
            chk("R9 done held", {7'd0, startup_done_o}, 8'h01);
        end
    endtask

    task automatic run_skip_mode(input logic [2:0] s, input string req);
        do_reset(s);
        sw_data_i = 8'hC3;
        @(posedge clk);
        #1 strap_i = ~s;
        @(negedge clk);
        chk("R2 mode", mode_reg_o, {5'd0, s});
        chk({req, " released"}, {7'd0, periph_rst_n_o}, 8'h01);
        chk("R9 done", {7'd0, startup_done_o}, 8'h01);
        for (int k = 0; k < N + 3; k++) begin
            chk({req, " no select"}, {7'd0, sw_cs_n_o}, 8'h01);
            chk({req, " cfg clear"}, cfg_switch_o, 8'h00);
            chk("R3 mode held", mode_reg_o, {5'd0, s});
            @(negedge clk);
        end
    endtask

    initial begin
        run_read_mode(3'b000, 8'hA7);   // bus mode
        run_read_mode(3'b010, 8'h3C);   // dual-port memory mode
        run_skip_mode(3'b001, "R7");
        run_skip_mode(3'b011, "R8");
        run_skip_mode(3'b111, "R8");
        run_read_mode(3'b000, 8'h00);
        run_read_mode(3'b010, 8'hFF);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule